// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the digital offset profile that a clock synthesizer's feedback divider follows to spread its output energy and lower EMI. While modulation is enabled, the block steps a signed offset word once per modulation tick. The word climbs toward an upper bound, then descends toward a lower bound, and the pattern repeats as a triangle. The climb increment and the descent increment are programmed separately, so the two slopes can differ. Converting the offset into a divider setting is done downstream and is not part of this block.

Two configuration bits shape the swing. The depth bit selects the narrow or the wide limit. The placement bit selects a swing centred on nominal, or a swing that lies entirely at or below nominal. When modulation is off, the offset returns to zero. The next enable starts a fresh profile from zero.

The control is a three-state machine. SS_IDLE holds the offset at zero. SS_RISE adds the climb increment on each tick. SS_FALL subtracts the descent increment on each tick. The transitions are:
- start_center: SS_IDLE to SS_RISE, on enable with centred placement.
- start_down: SS_IDLE to SS_FALL, on enable with below-nominal placement.
- peak: SS_RISE to SS_FALL, on the tick that reaches the upper bound.
- trough: SS_FALL to SS_RISE, on the tick that reaches the lower bound.
- stop: any running state to SS_IDLE, when enable is low.

Top module: `ssmod_profile_gen`

## Requirements
- R1: After reset, `offset` is 0, `strobe` is 0 and the machine is in SS_IDLE.
- R2: While `ss_enable` is 0, `offset` is 0 from the next clock on, whatever the other inputs are.
- R3: The first clock with `ss_enable` high leaves SS_IDLE without a tick. After that, a tick occurs every TICK_DIV clocks. `strobe` is high for the single cycle after each tick update, and `offset` changes only in those cycles, apart from returning to 0 on stop.
- R4: In SS_RISE each tick raises the offset by `up_step`+1 (`up_step` unsigned, 0..15), unless the bound is reached first.
- R5: In SS_FALL each tick lowers the offset by `down_step`+1 (unsigned, 0..15), unless the bound is reached first.
- R6: The limit L is FULL_SCALE/2 when `depth_quarter` is 1 and FULL_SCALE when it is 0.
- R7: With `center_type` = 1, the offset spans +L down to −L and starts by rising from 0.
- R8: With `center_type` = 0, the offset spans 0 down to −2·L and starts by falling from 0.
- R9: A step that would pass a bound lands exactly on the bound, and the direction reverses on that same tick. The offset never leaves the range −2·FULL_SCALE to +FULL_SCALE.
- R10: After a stop, re-enabling restarts the profile from 0 in the start state of the current placement.
- R11: If the bounds narrow mid-run, the next tick clamps the offset to the bound in its direction of travel and reverses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ss_enable | input | 1 | 1 runs modulation; 0 holds the offset at zero |
| depth_quarter | input | 1 | 1 selects the narrow limit FULL_SCALE/2; 0 selects FULL_SCALE |
| center_type | input | 1 | 1 selects a centred swing; 0 selects a below-nominal swing |
| up_step | input | STEP_W | Rising increment minus one |
| down_step | input | STEP_W | Falling decrement minus one |
| offset | output | OFF_W = clog2(FULL_SCALE)+3 | Signed two's-complement offset |
| strobe | output | 1 | High for one cycle after each tick update |

## Verification
A behavioural model tracks the profile cycle by cycle against each of the following stimulus patterns:
- Unequal slopes (4 up and 8 down) separate the two step paths, so a swapped climb and descent increment shows at once.
- A unit-slope run at narrow depth exposes any off-by-one at the limit or at the tick period.
- A step that cannot land evenly on the bound (10 against 32) proves that the offset clamps rather than overshoots.
- Below-nominal runs show that the range shifts down and that the first move is a fall.
- A mid-run disable followed by re-enable, and a depth narrowing while the offset sits above the new limit, cover restart and clamping.

// File: rtl/ssmod_pkg.sv
`timescale 1ns/1ps
package ssmod_pkg;

    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_RISE = 2'd1,
        SS_FALL = 2'd2
    } ss_state_e;

endpackage

// File: rtl/ssmod_tick.sv
`timescale 1ns/1ps
module ssmod_tick #(
    parameter int TICK_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(TICK_DIV + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ssmod_limits.sv
`timescale 1ns/1ps
module ssmod_limits #(
    parameter int FULL_SCALE = 4096,
    parameter int OFF_W      = 15
) (
    input  logic                    depth_quarter,
    input  logic                    center_type,
    output logic signed [OFF_W-1:0] lim_hi,
    output logic signed [OFF_W-1:0] lim_lo
);
    localparam logic signed [OFF_W-1:0] SPAN_WIDE   = OFF_W'(FULL_SCALE);
    localparam logic signed [OFF_W-1:0] SPAN_NARROW = OFF_W'(FULL_SCALE / 2);

    logic signed [OFF_W-1:0] span;

    always_comb begin
        span = depth_quarter ? SPAN_NARROW : SPAN_WIDE;
        if (center_type) begin
            lim_hi = span;
            lim_lo = -span;
        end else begin
            lim_hi = '0;
            lim_lo = -(span <<< 1);
        end
    end
endmodule

// File: rtl/ssmod_slew.sv
`timescale 1ns/1ps
module ssmod_slew #(
    parameter int OFF_W   = 15,
    parameter int STEP_W  = 4,
    parameter bit FALLING = 1'b0
) (
    input  logic signed [OFF_W-1:0] cur,
    input  logic [STEP_W-1:0]       step,
    input  logic signed [OFF_W-1:0] bound,
    output logic signed [OFF_W-1:0] nxt,
    output logic                    hit
);
    localparam int EXT_W = OFF_W + 2;

    logic signed [EXT_W-1:0] cur_x;
    logic signed [EXT_W-1:0] bnd_x;
    logic signed [EXT_W-1:0] dlt_x;
    logic signed [EXT_W-1:0] res_x;

    always_comb begin
        cur_x = EXT_W'(cur);
        bnd_x = EXT_W'(bound);
        dlt_x = $signed({{(EXT_W-STEP_W){1'b0}}, step}) + $signed(EXT_W'(1));
        if (FALLING) begin
            res_x = cur_x - dlt_x;
            hit   = (res_x <= bnd_x);
        end else begin
            res_x = cur_x + dlt_x;
            hit   = (res_x >= bnd_x);
        end
        nxt = hit ? bound : res_x[OFF_W-1:0];
    end
endmodule

// File: rtl/ssmod_fsm.sv
`timescale 1ns/1ps
module ssmod_fsm
    import ssmod_pkg::*;
#(
    parameter int OFF_W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ss_enable,
    input  logic                    center_type,
    input  logic                    tick,
    input  logic signed [OFF_W-1:0] rise_nxt,
    input  logic                    rise_hit,
    input  logic signed [OFF_W-1:0] fall_nxt,
    input  logic                    fall_hit,
    output ss_state_e               state,
    output logic signed [OFF_W-1:0] offset,
    output logic                    strobe
);
    ss_state_e state_q;
    ss_state_e state_d;

    assign state = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SS_IDLE: begin
                if (ss_enable) begin
                    state_d = center_type ? SS_RISE : SS_FALL;
                end
            end
            SS_RISE: begin
                if (!ss_enable) begin
                    state_d = SS_IDLE;
                end else if (tick && rise_hit) begin
                    state_d = SS_FALL;
                end
            end
            SS_FALL: begin
                if (!ss_enable) begin
                    state_d = SS_IDLE;
                end else if (tick && fall_hit) begin
                    state_d = SS_RISE;
                end
            end
            default: state_d = SS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset <= '0;
            strobe <= 1'b0;
        end else if (!ss_enable || state_q == SS_IDLE) begin
            offset <= '0;
            strobe <= 1'b0;
        end else if (tick) begin
            offset <= (state_q == SS_RISE) ? rise_nxt : fall_nxt;
            strobe <= 1'b1;
        end else begin
            strobe <= 1'b0;
        end
    end
endmodule

// File: rtl/ssmod_profile_gen.sv
`timescale 1ns/1ps
module ssmod_profile_gen
    import ssmod_pkg::*;
#(
    parameter int FULL_SCALE = 4096,
    parameter int TICK_DIV   = 32,
    parameter int STEP_W     = 4,
    localparam int OFF_W     = $clog2(FULL_SCALE) + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ss_enable,
    input  logic                    depth_quarter,
    input  logic                    center_type,
    input  logic [STEP_W-1:0]       up_step,
    input  logic [STEP_W-1:0]       down_step,
    output logic signed [OFF_W-1:0] offset,
    output logic                    strobe
);
    ss_state_e               run_state;
    logic                    tick;
    logic signed [OFF_W-1:0] lim_hi;
    logic signed [OFF_W-1:0] lim_lo;
    logic signed [OFF_W-1:0] slew_nxt [2];
    logic                    slew_hit [2];

    ssmod_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ss_enable && (run_state != SS_IDLE)),
        .tick (tick)
    );

    ssmod_limits #(.FULL_SCALE(FULL_SCALE), .OFF_W(OFF_W)) u_limits (
        .depth_quarter(depth_quarter),
        .center_type  (center_type),
        .lim_hi       (lim_hi),
        .lim_lo       (lim_lo)
    );

    for (genvar g = 0; g < 2; g++) begin : g_slew
        ssmod_slew #(.OFF_W(OFF_W), .STEP_W(STEP_W), .FALLING(g == 1)) u_slew (
            .cur  (offset),
            .step ((g == 0) ? up_step : down_step),
            .bound((g == 0) ? lim_hi : lim_lo),
            .nxt  (slew_nxt[g]),
            .hit  (slew_hit[g])
        );
    end

    ssmod_fsm #(.OFF_W(OFF_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ss_enable  (ss_enable),
        .center_type(center_type),
        .tick       (tick),
        .rise_nxt   (slew_nxt[0]),
        .rise_hit   (slew_hit[0]),
        .fall_nxt   (slew_nxt[1]),
        .fall_hit   (slew_hit[1]),
        .state      (run_state),
        .offset     (offset),
        .strobe     (strobe)
    );
endmodule

// File: rtl/ssmod_profile_chk.sv
`timescale 1ns/1ps
module ssmod_profile_chk
    import ssmod_pkg::*;
#(
    parameter int FULL_SCALE = 4096,
    parameter int STEP_W     = 4,
    parameter int OFF_W      = 15
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ss_enable,
    input logic [STEP_W-1:0]       up_step,
    input logic [STEP_W-1:0]       down_step,
    input logic signed [OFF_W-1:0] offset,
    input logic                    strobe,
    input ss_state_e               fsm_state
);
    int cur_i;
    int up_i;
    int dn_i;

    always_comb begin
        cur_i = int'(offset);
        up_i  = int'(up_step) + 1;
        dn_i  = int'(down_step) + 1;
    end

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_enable |=> (cur_i == 0));

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && $past(ss_enable)) |-> $stable(offset));

    assert_rise_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(fsm_state) == SS_RISE) |-> (cur_i - $past(cur_i) <= $past(up_i)));

    assert_fall_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(fsm_state) == SS_FALL) |-> ($past(cur_i) - cur_i <= $past(dn_i)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_i <= FULL_SCALE) && (cur_i >= -2 * FULL_SCALE));

    assert_idle_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_state) == SS_IDLE) |-> (cur_i == 0));
endmodule

bind ssmod_profile_gen ssmod_profile_chk #(
    .FULL_SCALE(FULL_SCALE),
    .STEP_W    (STEP_W),
    .OFF_W     (OFF_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ss_enable(ss_enable),
    .up_step  (up_step),
    .down_step(down_step),
    .offset   (offset),
    .strobe   (strobe),
    .fsm_state(run_state)
);

// File: tb/tb_ssmod_profile_gen.sv
`timescale 1ns/1ps
module tb_ssmod_profile_gen;
    localparam int FS    = 64;
    localparam int TD    = 3;
    localparam int SW    = 4;
    localparam int OW    = $clog2(FS) + 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ss_enable = 1'b0;
    logic                 depth_quarter = 1'b0;
    logic                 center_type = 1'b1;
    logic [SW-1:0]        up_step = '0;
    logic [SW-1:0]        down_step = '0;
    logic signed [OW-1:0] offset;
    logic                 strobe;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    bit    mon_on = 1'b0;
    string tag = "R1";

    // reference model state
    int m_off = 0;
    int m_cnt = 0;
    int m_dir = 0; // 0 idle, 1 rising, 2 falling
    int m_stb = 0;

    int seen_max = 0;
    int seen_min = 0;
    int cyc = 0;
    int last_stb = 0;
    bit have_stb = 1'b0;

    always #2.5 clk = ~clk;

    ssmod_profile_gen #(.FULL_SCALE(FS), .TICK_DIV(TD), .STEP_W(SW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ss_enable    (ss_enable),
        .depth_quarter(depth_quarter),
        .center_type  (center_type),
        .up_step      (up_step),
        .down_step    (down_step),
        .offset       (offset),
        .strobe       (strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int lim, hi, lo, v;
        mon_on <= 1'b1;
        if (!rst_n || !ss_enable) begin
            m_off = 0; m_cnt = 0; m_dir = 0; m_stb = 0;
        end else if (m_dir == 0) begin
            m_dir = center_type ? 1 : 2;
            m_stb = 0;
        end else begin
            lim = depth_quarter ? FS / 2 : FS;
            hi  = center_type ? lim : 0;
            lo  = center_type ? -lim : -2 * lim;
            if (m_cnt == TD - 1) begin
                m_cnt = 0;
                m_stb = 1;
                if (m_dir == 1) begin
                    v = m_off + int'(up_step) + 1;
                    if (v >= hi) begin v = hi; m_dir = 2; end
                end else begin
                    v = m_off - int'(down_step) - 1;
                    if (v <= lo) begin v = lo; m_dir = 1; end
                end
                m_off = v;
            end else begin
                m_cnt++;
                m_stb = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            chk(int'(offset) == m_off, tag, int'(offset), m_off);
            chk(int'(strobe) == m_stb, tag, int'(strobe), m_stb);
            if (int'(offset) > seen_max) seen_max = int'(offset);
            if (int'(offset) < seen_min) seen_min = int'(offset);
            if (!ss_enable) begin
                have_stb = 1'b0;
            end else if (strobe) begin
                if (have_stb) chk(cyc - last_stb == TD, "R3 tick spacing", cyc - last_stb, TD);
                have_stb = 1'b1;
                last_stb = cyc;
            end
        end
    end

    task automatic clear_span();
        seen_max = 0;
        seen_min = 0;
    endtask

    task automatic run_cfg(input bit dq, input bit ct, input int up, input int dn, input int cycles);
        @(negedge clk);
        depth_quarter = dq; center_type = ct;
        up_step = SW'(up); down_step = SW'(dn);
        ss_enable = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk);
        ss_enable = 1'b0;
        repeat (2) @(negedge clk);
        clear_span();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        chk(int'(offset) == 0, "R1 offset in reset", int'(offset), 0);
        chk(int'(strobe) == 0, "R1 strobe in reset", int'(strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(offset) == 0, "R1 offset after reset", int'(offset), 0);

        // R2: disabled, other inputs toggling
        tag = "R2";
        for (int i = 0; i < 12; i++) begin
            depth_quarter = i[0]; center_type = i[1];
            up_step = SW'(i); down_step = SW'(15 - i);
            @(negedge clk);
            chk(int'(offset) == 0, "R2 held at zero", int'(offset), 0);
        end

        // R4 R5 R7: centred, wide, unequal slopes
        tag = "R4 R5 R7 R3";
        clear_span();
        run_cfg(1'b0, 1'b1, 3, 7, 300);
        chk(seen_max == FS, "R7 centre peak", seen_max, FS);
        chk(seen_min == -FS, "R7 centre trough", seen_min, -FS);
        stop_run();

        // R6: narrow depth, unit slopes
        tag = "R6 R4 R5";
        run_cfg(1'b1, 1'b1, 0, 0, 600);
        chk(seen_max == FS / 2, "R6 narrow peak", seen_max, FS / 2);
        chk(seen_min == -FS / 2, "R6 narrow trough", seen_min, -FS / 2);
        stop_run();

        // R9: step 10 cannot land evenly on 32
        tag = "R9";
        run_cfg(1'b1, 1'b1, 9, 12, 200);
        chk(seen_max == FS / 2, "R9 clamp at peak", seen_max, FS / 2);
        chk(seen_min == -FS / 2, "R9 clamp at trough", seen_min, -FS / 2);
        stop_run();

        // R8: below-nominal placement, first move is a fall
        tag = "R8";
        @(negedge clk);
        center_type = 1'b0; depth_quarter = 1'b0; up_step = 4'd15; down_step = 4'd5;
        ss_enable = 1'b1;
        while (!strobe) @(negedge clk);
        chk(int'(offset) == -6, "R8 first step falls", int'(offset), -6);
        repeat (300) @(negedge clk);
        chk(seen_max == 0, "R8 down peak", seen_max, 0);
        chk(seen_min == -2 * FS, "R8 down trough", seen_min, -2 * FS);
        stop_run();

        // R10: stop mid-run and restart
        tag = "R10";
        run_cfg(1'b0, 1'b1, 5, 5, 40);
        @(negedge clk);
        ss_enable = 1'b0;
        @(negedge clk);
        chk(int'(offset) == 0, "R10 zero after stop", int'(offset), 0);
        repeat (4) @(negedge clk);
        up_step = 4'd2;
        ss_enable = 1'b1;
        while (!strobe) @(negedge clk);
        chk(int'(offset) == 3, "R10 restart from zero", int'(offset), 3);
        stop_run();

        // R11: narrowing depth while above the new limit
        tag = "R11";
        @(negedge clk);
        depth_quarter = 1'b0; center_type = 1'b1; up_step = 4'd7; down_step = 4'd7;
        ss_enable = 1'b1;
        while (int'(offset) < 48) @(negedge clk);
        depth_quarter = 1'b1;
        @(negedge clk);
        while (!strobe) @(negedge clk);
        chk(int'(offset) == FS / 2, "R11 clamp to new bound", int'(offset), FS / 2);
        @(negedge clk);
        while (!strobe) @(negedge clk);
        chk(int'(offset) == FS / 2 - 8, "R11 reversed after clamp", int'(offset), FS / 2 - 8);
        stop_run();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule